// File: doc/BRIEF.md
# Operand Register File with Unified Data-Space Access

This block is the working storage of a small 8-bit RISC core: thirty-two byte-wide registers that feed two operands to the ALU and take one result back in every cycle. The same registers also occupy the lowest addresses of the core's data address space. A single data-space port therefore reaches registers, a 64-entry I/O register array and a 128-byte SRAM through one address decoder. Load/store logic uses it for direct and indirect memory access, and a separate index port gives direct access to the I/O array.

The top six registers form three 16-bit pointers. Their values are always present on dedicated outputs. A pointer write-back port replaces both bytes of one pointer in a single edge, which the core uses for post-increment and pre-decrement addressing. All writes take effect on the rising clock edge and all reads are combinational. When several sources write the same location in one cycle, a fixed priority decides which value is stored.

Top module: `gpr_dataspace`

## Requirements
- R1: A write on the operand write port (wr_en, wr_addr, wr_data) is stored at the rising edge into register wr_addr (0..31), and the operand read ports show it with no added latency from the next cycle on.
- R2: The two operand read ports are independent and combinational: both may address any register in the same cycle, and equal addresses give equal data.
- R3: An operand read port returns the value the addressed register will hold after the coming edge (write-first), taking into account every write source that targets it in that cycle.
- R4: ptr_x = {r27, r26}, ptr_y = {r29, r28}, ptr_z = {r31, r30}, with the lower-numbered register as the low byte. The outputs reflect stored contents.
- R5: When ptr_we is high, ptr_sel selects the pointer (0 = X, 1 = Y, 2 = Z) whose two bytes both take ptr_wdata at the edge. ptr_sel = 3 changes nothing.
- R6: Data-space addresses 0x00..0x1F are registers 0..31. ds_rdata returns stored contents combinationally, without bypass, and ds_we writes at the edge.
- R7: Data-space addresses 0x20..0x5F are I/O entries 0..63 (entry = address − 0x20). The direct port (io_idx, io_we, io_wdata, io_rdata) reaches the same entries, and io_rdata is combinational.
- R8: Data-space addresses 0x60..0xDF are SRAM bytes 0..127 (byte = address − 0x60).
- R9: Addresses 0xE0..0xFF are unmapped: reads return 0x00 and writes change no storage.
- R10: If several writes target one register in the same cycle, the operand write wins over the pointer write-back, which wins over the data-space write. If a direct I/O write and a data-space write target one I/O entry, the direct write wins.
- R11: A synchronous active-high rst clears all registers, I/O entries and SRAM bytes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A data (write-first) |
| rd_b_addr | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B data (write-first) |
| wr_en | input | 1 | Result write enable |
| wr_addr | input | 5 | Result register index |
| wr_data | input | 8 | Result value |
| ds_addr | input | 8 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write value |
| ds_rdata | output | 8 | Data-space read value |
| io_idx | input | 6 | Direct I/O entry index |
| io_we | input | 1 | Direct I/O write enable |
| io_wdata | input | 8 | Direct I/O write value |
| io_rdata | output | 8 | Direct I/O read value |
| ptr_we | input | 1 | Pointer write-back enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Pointer write-back value |
| ptr_x | output | 16 | Pointer X {r27, r26} |
| ptr_y | output | 16 | Pointer Y {r29, r28} |
| ptr_z | output | 16 | Pointer Z {r31, r30} |

## Verification
All reads are combinational, so the operand ports, ds_rdata and io_rdata are due in the same cycle as their address, and operand reads already include that cycle's writes. Stores become visible one edge later on ds_rdata, io_rdata and the pointer outputs. The bench drives inputs at the falling edge and compares all outputs one nanosecond later against a model that still holds the pre-edge state. It advances the model only after the rising edge, so each result is sampled in the cycle it is due.

// File: rtl/dsrf_pkg.sv
package dsrf_pkg;

  typedef enum logic [1:0] {RGN_GPR, RGN_IO, RGN_SRAM, RGN_NONE} region_e;

  // Classify a data-space address; regions are stacked from address zero.
  function automatic region_e ds_region(input int unsigned addr, input int unsigned nreg,
                                        input int unsigned nio, input int unsigned nsram);
    if (addr < nreg)              return RGN_GPR;
    if (addr < nreg + nio)        return RGN_IO;
    if (addr < nreg + nio + nsram) return RGN_SRAM;
    return RGN_NONE;
  endfunction

  // Index of the low byte of pointer sel (0..2) inside the register file.
  function automatic int unsigned ptr_low_reg(input int unsigned nreg, input int unsigned sel);
    return nreg - 6 + 2 * sel;
  endfunction

endpackage

// File: rtl/dsrf_gpr_bank.sv
module dsrf_gpr_bank
  import dsrf_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAW-1:0]    rda_addr,
  output logic [DW-1:0]     rda_data,
  input  logic [RAW-1:0]    rdb_addr,
  output logic [DW-1:0]     rdb_data,
  input  logic              op_we,
  input  logic [RAW-1:0]    op_addr,
  input  logic [DW-1:0]     op_wdata,
  input  logic              pw_we,
  input  logic [1:0]        pw_sel,
  input  logic [2*DW-1:0]   pw_wdata,
  input  logic              ds_we,
  input  logic [RAW-1:0]    ds_idx,
  input  logic [DW-1:0]     ds_wdata,
  output logic [DW-1:0]     ds_rdata,
  output logic [6*DW-1:0]   ptr_flat
);

  logic [DW-1:0] q   [NREG];
  logic [DW-1:0] nxt [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit IS_PTR = (i >= NREG - 6);
    localparam int PSEL   = IS_PTR ? (i - (NREG - 6)) / 2 : 3;
    localparam bit IS_HI  = IS_PTR && (i != int'(ptr_low_reg(NREG, PSEL)));

    // Lowest priority first: data space, then pointer, then operand write.
    always_comb begin
      nxt[i] = q[i];
      if (ds_we && ds_idx == RAW'(i)) nxt[i] = ds_wdata;
      if (IS_PTR && pw_we && pw_sel == 2'(PSEL))
        nxt[i] = IS_HI ? pw_wdata[2*DW-1:DW] : pw_wdata[DW-1:0];
      if (op_we && op_addr == RAW'(i)) nxt[i] = op_wdata;
    end

    always_ff @(posedge clk) begin
      if (rst) q[i] <= '0;
      else     q[i] <= nxt[i];
    end
  end

  assign rda_data = nxt[rda_addr];
  assign rdb_data = nxt[rdb_addr];
  assign ds_rdata = q[ds_idx];

  for (genvar p = 0; p < 3; p++) begin : g_ptr
    localparam int LO = int'(ptr_low_reg(NREG, p));
    assign ptr_flat[p*2*DW +: 2*DW] = {q[LO+1], q[LO]};
  end

endmodule

// File: rtl/dsrf_io_bank.sv
module dsrf_io_bank #(
  parameter int DW  = 8,
  parameter int NIO = 64,
  localparam int IAW = $clog2(NIO)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ds_we,
  input  logic [IAW-1:0] ds_idx,
  input  logic [DW-1:0]  ds_wdata,
  output logic [DW-1:0]  ds_rdata,
  input  logic           dir_we,
  input  logic [IAW-1:0] dir_idx,
  input  logic [DW-1:0]  dir_wdata,
  output logic [DW-1:0]  dir_rdata
);

  logic [DW-1:0] q [NIO];

  for (genvar i = 0; i < NIO; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                               q[i] <= '0;
      else if (dir_we && dir_idx == IAW'(i)) q[i] <= dir_wdata;
      else if (ds_we && ds_idx == IAW'(i))   q[i] <= ds_wdata;
    end
  end

  assign ds_rdata  = q[ds_idx];
  assign dir_rdata = q[dir_idx];

endmodule

// File: rtl/dsrf_sram.sv
module dsrf_sram #(
  parameter int DW    = 8,
  parameter int NSRAM = 128,
  localparam int SAW  = $clog2(NSRAM)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [SAW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [NSRAM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSRAM; k++) mem[k] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/gpr_dataspace.sv
module gpr_dataspace
  import dsrf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREG  = 32,
  parameter int NIO   = 64,
  parameter int NSRAM = 128,
  parameter int AW    = 8,
  localparam int RAW  = $clog2(NREG),
  localparam int IAW  = $clog2(NIO),
  localparam int SAW  = $clog2(NSRAM),
  localparam int IO_BASE   = NREG,
  localparam int SRAM_BASE = NREG + NIO
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rd_a_addr,
  output logic [DW-1:0]   rd_a_data,
  input  logic [RAW-1:0]  rd_b_addr,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [RAW-1:0]  wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   ds_addr,
  input  logic            ds_we,
  input  logic [DW-1:0]   ds_wdata,
  output logic [DW-1:0]   ds_rdata,
  input  logic [IAW-1:0]  io_idx,
  input  logic            io_we,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  input  logic            ptr_we,
  input  logic [1:0]      ptr_sel,
  input  logic [2*DW-1:0] ptr_wdata,
  output logic [2*DW-1:0] ptr_x,
  output logic [2*DW-1:0] ptr_y,
  output logic [2*DW-1:0] ptr_z
);

  // Decode of the data-space address into region and local index.
  region_e        rgn;
  logic           ds_hit_gpr, ds_hit_io, ds_hit_sram;
  logic [RAW-1:0] gpr_ds_idx;
  logic [IAW-1:0] io_ds_idx;
  logic [SAW-1:0] sram_ds_idx;

  assign rgn         = ds_region(int'(ds_addr), NREG, NIO, NSRAM);
  assign ds_hit_gpr  = (rgn == RGN_GPR);
  assign ds_hit_io   = (rgn == RGN_IO);
  assign ds_hit_sram = (rgn == RGN_SRAM);
  assign gpr_ds_idx  = RAW'(ds_addr);
  assign io_ds_idx   = IAW'(ds_addr - AW'(IO_BASE));
  assign sram_ds_idx = SAW'(ds_addr - AW'(SRAM_BASE));

  // Named internal events for the checker.
  logic opw_overrides_dsw, iow_overrides_dsw;
  assign opw_overrides_dsw = wr_en && ds_we && ds_hit_gpr && (wr_addr == gpr_ds_idx);
  assign iow_overrides_dsw = io_we && ds_we && ds_hit_io && (io_idx == io_ds_idx);

  logic [DW-1:0]   gpr_rd, io_rd, sram_rd;
  logic [6*DW-1:0] ptr_flat;

  dsrf_gpr_bank #(.DW(DW), .NREG(NREG)) u_gpr (
    .clk(clk), .rst(rst),
    .rda_addr(rd_a_addr), .rda_data(rd_a_data),
    .rdb_addr(rd_b_addr), .rdb_data(rd_b_data),
    .op_we(wr_en), .op_addr(wr_addr), .op_wdata(wr_data),
    .pw_we(ptr_we), .pw_sel(ptr_sel), .pw_wdata(ptr_wdata),
    .ds_we(ds_we && ds_hit_gpr), .ds_idx(gpr_ds_idx), .ds_wdata(ds_wdata),
    .ds_rdata(gpr_rd), .ptr_flat(ptr_flat)
  );

  dsrf_io_bank #(.DW(DW), .NIO(NIO)) u_io (
    .clk(clk), .rst(rst),
    .ds_we(ds_we && ds_hit_io), .ds_idx(io_ds_idx), .ds_wdata(ds_wdata), .ds_rdata(io_rd),
    .dir_we(io_we), .dir_idx(io_idx), .dir_wdata(io_wdata), .dir_rdata(io_rdata)
  );

  dsrf_sram #(.DW(DW), .NSRAM(NSRAM)) u_sram (
    .clk(clk), .rst(rst),
    .we(ds_we && ds_hit_sram), .idx(sram_ds_idx), .wdata(ds_wdata), .rdata(sram_rd)
  );

  always_comb begin
    unique case (rgn)
      RGN_GPR:  ds_rdata = gpr_rd;
      RGN_IO:   ds_rdata = io_rd;
      RGN_SRAM: ds_rdata = sram_rd;
      default:  ds_rdata = '0;
    endcase
  end

  assign ptr_x = ptr_flat[0*2*DW +: 2*DW];
  assign ptr_y = ptr_flat[1*2*DW +: 2*DW];
  assign ptr_z = ptr_flat[2*2*DW +: 2*DW];

endmodule

// File: rtl/dsrf_checker.sv
module dsrf_checker #(
  parameter int DW    = 8,
  parameter int NREG  = 32,
  parameter int NIO   = 64,
  parameter int NSRAM = 128,
  parameter int AW    = 8,
  localparam int RAW  = $clog2(NREG),
  localparam int IAW  = $clog2(NIO),
  localparam int MAP_END = NREG + NIO + NSRAM
) (
  input logic            clk,
  input logic            rst,
  input logic [RAW-1:0]  rd_a_addr,
  input logic [DW-1:0]   rd_a_data,
  input logic [RAW-1:0]  rd_b_addr,
  input logic [DW-1:0]   rd_b_data,
  input logic            wr_en,
  input logic [RAW-1:0]  wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [AW-1:0]   ds_addr,
  input logic            ds_we,
  input logic [DW-1:0]   ds_wdata,
  input logic [DW-1:0]   ds_rdata,
  input logic [IAW-1:0]  io_idx,
  input logic            io_we,
  input logic [DW-1:0]   io_wdata,
  input logic [DW-1:0]   io_rdata,
  input logic            ptr_we,
  input logic [1:0]      ptr_sel,
  input logic [2*DW-1:0] ptr_wdata,
  input logic [2*DW-1:0] ptr_x,
  input logic [2*DW-1:0] ptr_y,
  input logic [2*DW-1:0] ptr_z,
  input logic            opw_overrides_dsw,
  input logic            iow_overrides_dsw
);

  assert_stored_result_R1: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) && rd_a_addr == $past(wr_addr) && !wr_en && !ptr_we && !ds_we
    |-> rd_a_data == $past(wr_data));

  assert_equal_ports_R2: assert property (@(posedge clk) disable iff (rst)
    rd_a_addr == rd_b_addr |-> rd_a_data == rd_b_data);

  assert_opread_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_a_addr == wr_addr |-> rd_a_data == wr_data);

  assert_ptr_x_update_R5: assert property (@(posedge clk) disable iff (rst)
    $past(ptr_we && ptr_sel == 2'd0 && !wr_en && !ds_we) && !$past(rst)
    |-> ptr_x == $past(ptr_wdata));

  assert_ptr_none_R5: assert property (@(posedge clk) disable iff (rst)
    $past(ptr_we && ptr_sel == 2'd3 && !wr_en && !ds_we) && !$past(rst)
    |-> $stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z));

  assert_ds_store_read_R6: assert property (@(posedge clk) disable iff (rst)
    $past(ds_we && !wr_en && !ptr_we && !io_we) && !$past(rst) &&
    ds_addr == $past(ds_addr) && int'(ds_addr) < MAP_END
    |-> ds_rdata == $past(ds_wdata));

  assert_io_alias_R7: assert property (@(posedge clk) disable iff (rst)
    int'(ds_addr) == NREG + int'(io_idx) |-> ds_rdata == io_rdata);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    int'(ds_addr) >= MAP_END |-> ds_rdata == '0);

  assert_opw_priority_R10: assert property (@(posedge clk) disable iff (rst)
    $past(opw_overrides_dsw) && !$past(rst) && ds_addr == $past(ds_addr)
    |-> ds_rdata == $past(wr_data));

  assert_iow_priority_R10: assert property (@(posedge clk) disable iff (rst)
    $past(iow_overrides_dsw) && !$past(rst) && io_idx == $past(io_idx)
    |-> io_rdata == $past(io_wdata));

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ptr_x == '0 && ptr_y == '0 && ptr_z == '0 && ds_rdata == '0 && io_rdata == '0);

endmodule

bind gpr_dataspace dsrf_checker #(
  .DW(DW), .NREG(NREG), .NIO(NIO), .NSRAM(NSRAM), .AW(AW)
) u_chk (.*);

// File: tb/gpr_dataspace_tb.sv
`timescale 1ns/1ps
module gpr_dataspace_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [7:0]  rd_a_data, rd_b_data, wr_data;
  logic        wr_en;
  logic [7:0]  ds_addr, ds_wdata, ds_rdata;
  logic        ds_we;
  logic [5:0]  io_idx;
  logic        io_we;
  logic [7:0]  io_wdata, io_rdata;
  logic        ptr_we;
  logic [1:0]  ptr_sel;
  logic [15:0] ptr_wdata, ptr_x, ptr_y, ptr_z;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_reg [32];
  logic [7:0] m_io  [64];
  logic [7:0] m_sram[128];

  always #4 clk = ~clk;

  gpr_dataspace u_dut (.*);

  // Post-edge value of register r under the currently driven writes.
  function automatic logic [7:0] reg_after(int r);
    if (wr_en && int'(wr_addr) == r) return wr_data;
    if (ptr_we && ptr_sel != 2'd3 && r == 26 + 2 * int'(ptr_sel)) return ptr_wdata[7:0];
    if (ptr_we && ptr_sel != 2'd3 && r == 27 + 2 * int'(ptr_sel)) return ptr_wdata[15:8];
    if (ds_we && int'(ds_addr) == r) return ds_wdata;
    return m_reg[r];
  endfunction

  function automatic logic [7:0] ds_expect(int a);
    if (a < 32)  return m_reg[a];
    if (a < 96)  return m_io[a-32];
    if (a < 224) return m_sram[a-96];
    return 8'h00;
  endfunction

  function automatic string ds_tag(int a);
    if (a < 32)  return "R6";
    if (a < 96)  return "R7";
    if (a < 224) return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; ds_we = 0; io_we = 0; ptr_we = 0; ptr_sel = 2'd3;
  endtask

  task automatic commit();
    logic [7:0] nr [32];
    logic [7:0] ni [64];
    for (int r = 0; r < 32; r++) nr[r] = reg_after(r);
    for (int i = 0; i < 64; i++) begin
      ni[i] = m_io[i];
      if (io_we && int'(io_idx) == i) ni[i] = io_wdata;
      else if (ds_we && int'(ds_addr) == i + 32) ni[i] = ds_wdata;
    end
    if (ds_we && ds_addr >= 8'd96 && ds_addr < 8'd224) m_sram[int'(ds_addr) - 96] = ds_wdata;
    for (int r = 0; r < 32; r++) m_reg[r] = nr[r];
    for (int i = 0; i < 64; i++) m_io[i] = ni[i];
    if (rst) begin
      for (int r = 0; r < 32; r++)  m_reg[r] = 8'h00;
      for (int i = 0; i < 64; i++)  m_io[i] = 8'h00;
      for (int k = 0; k < 128; k++) m_sram[k] = 8'h00;
    end
  endtask

  // Inputs are set at the falling edge; check 1 ns later, then clock.
  task automatic tick();
    #1;
    if (!rst) begin
      check("R3", {8'h00, rd_a_data}, {8'h00, reg_after(int'(rd_a_addr))});
      check("R2", {8'h00, rd_b_data}, {8'h00, reg_after(int'(rd_b_addr))});
      check(ds_tag(int'(ds_addr)), {8'h00, ds_rdata}, {8'h00, ds_expect(int'(ds_addr))});
      check("R7", {8'h00, io_rdata}, {8'h00, m_io[io_idx]});
      check("R4", ptr_x, {m_reg[27], m_reg[26]});
      check("R4", ptr_y, {m_reg[29], m_reg[28]});
      check("R4", ptr_z, {m_reg[31], m_reg[30]});
    end
    @(posedge clk);
    #1 commit();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++)  m_reg[r] = 8'hxx;
    rst = 1; idle();
    rd_a_addr = 0; rd_b_addr = 0; wr_addr = 0; wr_data = 0;
    ds_addr = 0; ds_wdata = 0; io_idx = 0; io_wdata = 0; ptr_wdata = 0;
    @(negedge clk); tick(); tick();
    rst = 0;

    // R11: everything reads zero after reset
    ds_addr = 8'h1F; io_idx = 6'd63; #1;
    check("R11", {ptr_x[7:0], ds_rdata}, 16'h0000);
    check("R11", {8'h00, io_rdata}, 16'h0000);
    ds_addr = 8'hDF; #1 check("R11", {8'h00, ds_rdata}, 16'h0000);
    ds_addr = 8'h40; #1 check("R11", {8'h00, ds_rdata}, 16'h0000);
    @(negedge clk);

    // R1: operand write, then read without bypass
    wr_en = 1; wr_addr = 5'd5; wr_data = 8'hC3; tick();
    idle(); rd_a_addr = 5'd5; rd_b_addr = 5'd5; #1;
    check("R1", {8'h00, rd_a_data}, 16'h00C3);
    check("R2", {8'h00, rd_b_data}, 16'h00C3);
    tick();

    // R5: pointer Y write-back, then select 3 has no effect
    ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'hBEEF; tick();
    idle(); #1 check("R5", ptr_y, 16'hBEEF);
    ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'h1357; tick();
    idle(); #1;
    check("R5", ptr_y, 16'hBEEF);
    check("R5", ptr_x, 16'h0000);
    check("R5", ptr_z, 16'h0000);
    tick();

    // R10: operand write beats data-space write on register 7
    wr_en = 1; wr_addr = 5'd7; wr_data = 8'hAA; ds_we = 1; ds_addr = 8'h07; ds_wdata = 8'h55; tick();
    idle(); ds_addr = 8'h07; #1 check("R10", {8'h00, ds_rdata}, 16'h00AA);
    tick();
    // R10: pointer write beats data-space write on r30
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h1234; ds_we = 1; ds_addr = 8'd30; ds_wdata = 8'h99; tick();
    idle(); #1 check("R10", ptr_z, 16'h1234);
    tick();
    // R10: operand write beats pointer write on r31
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'h5678; wr_en = 1; wr_addr = 5'd31; wr_data = 8'h77; tick();
    idle(); #1 check("R10", ptr_z, 16'h7778);
    tick();
    // R10: direct I/O write beats data-space write on entry 3
    io_we = 1; io_idx = 6'd3; io_wdata = 8'h11; ds_we = 1; ds_addr = 8'h23; ds_wdata = 8'h22; tick();
    idle(); io_idx = 6'd3; #1 check("R10", {8'h00, io_rdata}, 16'h0011);
    tick();

    // R7: data-space write at 0x25 appears at direct index 5
    ds_we = 1; ds_addr = 8'h25; ds_wdata = 8'h5A; tick();
    idle(); io_idx = 6'd5; #1 check("R7", {8'h00, io_rdata}, 16'h005A);
    tick();
    // R8: top SRAM byte
    ds_we = 1; ds_addr = 8'hDF; ds_wdata = 8'h3C; tick();
    idle(); ds_addr = 8'hDF; #1 check("R8", {8'h00, ds_rdata}, 16'h003C);
    tick();
    // R9: unmapped write leaves SRAM, I/O and registers untouched
    ds_we = 1; ds_addr = 8'hE0; ds_wdata = 8'hFF; tick();
    idle(); ds_addr = 8'hE0; #1 check("R9", {8'h00, ds_rdata}, 16'h0000);
    ds_addr = 8'h60; #1 check("R9", {8'h00, ds_rdata}, 16'h0000);
    ds_addr = 8'h00; #1 check("R9", {8'h00, ds_rdata}, 16'h0000);
    ds_addr = 8'h20; #1 check("R9", {8'h00, ds_rdata}, 16'h0000);
    tick();

    // Random traffic against the model (fixed seed)
    void'($urandom(32'h5EED_0B1A));
    for (int n = 0; n < 4000; n++) begin
      rst       = ($urandom % 300) == 0;
      rd_a_addr = 5'($urandom); rd_b_addr = 5'($urandom);
      wr_en     = $urandom % 2; wr_addr = 5'($urandom); wr_data = 8'($urandom);
      ds_we     = $urandom % 2; ds_addr = 8'($urandom); ds_wdata = 8'($urandom);
      if ($urandom % 4 == 0) ds_addr = {3'b000, wr_addr};
      io_we     = ($urandom % 3) == 0; io_idx = 6'($urandom); io_wdata = 8'($urandom);
      if ($urandom % 4 == 0) ds_addr = 8'(int'(io_idx) + 32);
      ptr_we    = ($urandom % 3) == 0; ptr_sel = 2'($urandom); ptr_wdata = 16'($urandom);
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule